// File: doc/BRIEF.md
# Banked Register File With Hardware Stack

This block holds the 128-byte lower data memory of a small 8-bit controller core. The core's execution unit reaches it in three ways. The first is a register number, which the two bank-select bits from the status word steer into one of four eight-byte banks at the bottom of the memory. The second is a plain byte address, which serves both direct and pointer-based (indirect) accesses. The third is a bit address, which selects one bit of the sixteen bytes that start at 20h.

A separate stack port pushes and pops bytes through an internal 8-bit stack pointer. That port has priority over the access port whenever both want to write. Read results come out one clock after the command. Bit writes are read-modify-write operations that finish in one clock.

Top module: `regstk_top`

## Requirements
- R1: Synchronous active-low reset sets the stack pointer to 07h, `rdata_o` and `pop_data_o` to 00h, and every byte of the memory to 00h.
- R2: A register command (cmd_i 1 = read, 2 = write) with bank bits k and register number n addresses byte 8*k + n. For example, bank 2 register 5 is byte 15h.
- R3: A byte command (cmd_i 3 = read, 4 = write) at an address from 00h to 7Fh reads or writes that byte. Read data appears on `rdata_o` after the next rising edge. A read in the same cycle as a write to the same byte returns the old value.
- R4: A byte command at an address of 80h or above does not change the memory, and a read there returns 00h.
- R5: A bit command (cmd_i 5 = read, 6 = write) at bit address b uses bit b[2:0] of byte 20h + b[6:3]. A bit read returns that bit in `rdata_o[0]` with zeros above it. A bit write stores `wdata_i[0]` and leaves the other seven bits of the byte unchanged.
- R6: A bit command at a bit address of 80h or above does not change the memory, and a read there returns 00h.
- R7: A push first increments the stack pointer. It then writes `push_data_i` at the new pointer value, but only if that value is below 80h. Otherwise the data is dropped.
- R8: A pop loads `pop_data_o` with the byte at the current pointer (00h if the pointer is 80h or above) and then decrements the pointer. Together with R7 this gives last-in, first-out order.
- R9: When push and pop are requested in the same cycle, only the push is carried out. The pointer increments once and `pop_data_o` holds its value.
- R10: A push in the same cycle as an access-port write drops the access-port write. Access reads, and pops without a push, proceed alongside other operations.
- R11: The stack pointer wraps modulo 256: a push at FFh moves it to 00h and writes byte 00h, and a pop at 00h moves it to FFh.
- R12: cmd_i 0 and 7 are idle. `rdata_o` changes only after a read command (1, 3 or 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Access-port command code |
| bank_sel_i | input | 2 | Active register bank from the status word |
| reg_num_i | input | 3 | Register number within the bank |
| addr_i | input | 8 | Byte address or bit address |
| wdata_i | input | 8 | Write data; bit writes use bit 0 |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop request |
| rdata_o | output | 8 | Registered access-port read data |
| pop_data_o | output | 8 | Registered popped byte |
| sp_o | output | 8 | Current stack pointer |

## Verification
Two pairs of operations can fall in the same cycle. The stack port can request a push and a pop together, and a push can collide with an access-port write, including a bit read-modify-write. Directed cycles drive both collisions at known pointer values. Random traffic also asserts push and pop independently with a quarter probability each, against random access commands. Each collision is judged on three things: the pointer moves by exactly one, `pop_data_o` holds its value, and later reads show that the access write never landed while the pushed byte did.

// File: rtl/regstk_pkg.sv
// Package: shared command codes and stack-operation resolution for the
// banked register file. Assumes a 3-bit access command field.
package regstk_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_REG_RD  = 3'd1,
        CMD_REG_WR  = 3'd2,
        CMD_BYTE_RD = 3'd3,
        CMD_BYTE_WR = 3'd4,
        CMD_BIT_RD  = 3'd5,
        CMD_BIT_WR  = 3'd6,
        CMD_RSVD    = 3'd7
    } acc_cmd_e;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stack_op_e;

    // Push has priority over pop when both arrive together.
    function automatic stack_op_e pick_stack_op(input logic push, input logic pop);
        if (push) return STK_PUSH;
        if (pop)  return STK_POP;
        return STK_HOLD;
    endfunction

endpackage

// File: rtl/regstk_decode.sv
// Module: access-port address decoder.
// Turns a command plus bank/register/byte/bit fields into a byte index,
// a bit position, read/write strobes and an in-range flag.
// Assumes: the register banks sit at the bottom of memory and the bit
// area starts at BIT_BASE. Purely combinational.
module regstk_decode
    import regstk_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int RAM_BYTES     = 128,
    parameter int BANKS         = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BIT_BASE      = 32,
    parameter int BIT_BYTES     = 16,
    parameter int ADDR_W        = 8,
    localparam int IDX_W        = $clog2(RAM_BYTES),
    localparam int POS_W        = $clog2(DATA_W),
    localparam int BANK_W       = $clog2(BANKS),
    localparam int REG_W        = $clog2(REGS_PER_BANK)
) (
    input  acc_cmd_e          cmd,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              is_bit,
    output logic              in_range,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [POS_W-1:0]  bit_pos
);

    localparam int BIT_COUNT = BIT_BYTES * DATA_W;

    logic [IDX_W-1:0] reg_idx;
    logic [IDX_W-1:0] bit_byte_idx;

    // Register number relocated into the selected bank.
    assign reg_idx = IDX_W'(bank_sel) * IDX_W'(REGS_PER_BANK) + IDX_W'(reg_num);

    // Byte that holds the addressed bit.
    assign bit_byte_idx = IDX_W'(BIT_BASE) + IDX_W'(addr >> POS_W);

    // Select address source, range check and strobes for the command.
    always_comb begin
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        is_bit   = 1'b0;
        in_range = 1'b0;
        byte_idx = '0;
        bit_pos  = addr[POS_W-1:0];
        case (cmd)
            CMD_REG_RD, CMD_REG_WR: begin
                byte_idx = reg_idx;
                in_range = 1'b1;
            end
            CMD_BYTE_RD, CMD_BYTE_WR: begin
                byte_idx = addr[IDX_W-1:0];
                in_range = (addr < ADDR_W'(RAM_BYTES));
            end
            CMD_BIT_RD, CMD_BIT_WR: begin
                byte_idx = bit_byte_idx;
                is_bit   = 1'b1;
                in_range = (addr < ADDR_W'(BIT_COUNT));
            end
            default: ;
        endcase
        rd_en = (cmd == CMD_REG_RD) || (cmd == CMD_BYTE_RD) || (cmd == CMD_BIT_RD);
        wr_en = (cmd == CMD_REG_WR) || (cmd == CMD_BYTE_WR) || (cmd == CMD_BIT_WR);
    end

endmodule

// File: rtl/regstk_sp.sv
// Module: stack pointer register.
// Increments on push and decrements on pop; push wins a tie. Wraps
// modulo 2**SP_W. Also offers the pre-incremented value, which is
// the address a push writes to.
module regstk_sp
    import regstk_pkg::*;
#(
    parameter int SP_W     = 8,
    parameter int SP_RESET = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_inc
);

    logic [SP_W-1:0] sp_q;
    stack_op_e       op;

    assign op     = pick_stack_op(push, pop);
    assign sp     = sp_q;
    assign sp_inc = sp_q + SP_W'(1);

    // Pointer update: reset value, increment, decrement or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_W'(SP_RESET);
        end else begin
            case (op)
                STK_PUSH: sp_q <= sp_inc;
                STK_POP:  sp_q <= sp_q - SP_W'(1);
                default:  sp_q <= sp_q;
            endcase
        end
    end

    assert_sp_reset_R1: assert property (@(posedge clk)
        !rst_n |=> sp == SP_W'(SP_RESET));

    assert_push_incr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) + SP_W'(1));

    assert_pop_decr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp == $past(sp) - SP_W'(1));

    assert_tie_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> sp != $past(sp) - SP_W'(1));

    assert_wrap_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && sp == '1) |=> sp == '0);

    assert_sp_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp));

endmodule

// File: rtl/regstk_store.sv
// Module: flop-based byte storage with one write port and two
// combinational read ports (access port and stack port).
// All bytes clear on synchronous reset.
module regstk_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] row_q [DEPTH];
    logic [DEPTH-1:0]  row_we;

    // Per-row write enable decode.
    for (genvar i = 0; i < DEPTH; i++) begin : g_row_we
        assign row_we[i] = we && (waddr == IDX_W'(i));
    end

    // Storage update: clear on reset, else write the enabled row.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                row_q[i] <= '0;
            end else if (row_we[i]) begin
                row_q[i] <= wdata;
            end
        end
    end

    assign rdata_a = row_q[raddr_a];
    assign rdata_b = row_q[raddr_b];

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> row_q[$past(waddr)] == $past(wdata));

    assert_one_row_written: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));

endmodule

// File: rtl/regstk_top.sv
// Module: banked register file with hardware stack (top).
// Access port: register, byte and bit reads/writes with a one-cycle read
// latency. Stack port: push/pop through an internal pointer. A push owns
// the write port; a colliding access write is dropped. Bit writes are
// read-modify-write in a single cycle.
module regstk_top
    import regstk_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int RAM_BYTES     = 128,
    parameter int BANKS         = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BIT_BASE      = 32,
    parameter int BIT_BYTES     = 16,
    parameter int ADDR_W        = 8,
    parameter int SP_W          = 8,
    parameter int SP_RESET      = 7,
    localparam int BANK_W       = $clog2(BANKS),
    localparam int REG_W        = $clog2(REGS_PER_BANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic [REG_W-1:0]  reg_num_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] pop_data_o,
    output logic [SP_W-1:0]   sp_o
);

    localparam int IDX_W = $clog2(RAM_BYTES);
    localparam int POS_W = $clog2(DATA_W);

    acc_cmd_e          cmd;
    logic              dec_rd;
    logic              dec_wr;
    logic              dec_bit;
    logic              dec_ok;
    logic [IDX_W-1:0]  dec_idx;
    logic [POS_W-1:0]  dec_pos;
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   sp_inc;
    logic              push_ok;
    logic              pop_ok;
    logic [DATA_W-1:0] acc_rbyte;
    logic [DATA_W-1:0] stk_rbyte;
    logic [DATA_W-1:0] merged;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] pop_q;

    assign cmd = acc_cmd_e'(cmd_i);

    regstk_decode #(
        .DATA_W(DATA_W), .RAM_BYTES(RAM_BYTES), .BANKS(BANKS),
        .REGS_PER_BANK(REGS_PER_BANK), .BIT_BASE(BIT_BASE),
        .BIT_BYTES(BIT_BYTES), .ADDR_W(ADDR_W)
    ) i_decode (
        .cmd(cmd), .bank_sel(bank_sel_i), .reg_num(reg_num_i), .addr(addr_i),
        .rd_en(dec_rd), .wr_en(dec_wr), .is_bit(dec_bit), .in_range(dec_ok),
        .byte_idx(dec_idx), .bit_pos(dec_pos)
    );

    regstk_sp #(
        .SP_W(SP_W), .SP_RESET(SP_RESET)
    ) i_sp (
        .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i),
        .sp(sp), .sp_inc(sp_inc)
    );

    regstk_store #(
        .DATA_W(DATA_W), .DEPTH(RAM_BYTES)
    ) i_store (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(dec_idx), .rdata_a(acc_rbyte),
        .raddr_b(sp[IDX_W-1:0]), .rdata_b(stk_rbyte)
    );

    // Stack addresses outside the memory are dropped or read as zero.
    assign push_ok = (sp_inc < SP_W'(RAM_BYTES));
    assign pop_ok  = (sp < SP_W'(RAM_BYTES));

    // Bit write: replace one bit of the current byte.
    always_comb begin
        merged          = acc_rbyte;
        merged[dec_pos] = wdata_i[0];
    end

    // Write-port arbitration: a push owns the port, else the access write.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = dec_idx;
        mem_wdata = dec_bit ? merged : wdata_i;
        if (push_i) begin
            mem_we    = push_ok;
            mem_waddr = sp_inc[IDX_W-1:0];
            mem_wdata = push_data_i;
        end else if (dec_wr && dec_ok) begin
            mem_we = 1'b1;
        end
    end

    // Access read register: loads only on read commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (dec_rd) begin
            if (!dec_ok)      rdata_q <= '0;
            else if (dec_bit) rdata_q <= {{(DATA_W-1){1'b0}}, acc_rbyte[dec_pos]};
            else              rdata_q <= acc_rbyte;
        end
    end

    // Pop data register: loads on a pop that is not overridden by a push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_q <= '0;
        end else if (pop_i && !push_i) begin
            pop_q <= pop_ok ? stk_rbyte : '0;
        end
    end

    assign rdata_o    = rdata_q;
    assign pop_data_o = pop_q;
    assign sp_o       = sp;

    assert_oob_byte_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd3 && addr_i >= ADDR_W'(RAM_BYTES)) |=> rdata_o == '0);

    assert_bit_read_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd5) |=> rdata_o[DATA_W-1:1] == '0);

    assert_oob_bit_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd5 && addr_i >= ADDR_W'(BIT_BYTES * DATA_W)) |=> rdata_o == '0);

    assert_oob_pop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && sp_o >= SP_W'(RAM_BYTES)) |=> pop_data_o == '0);

    assert_pop_held_on_tie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(pop_data_o));

    assert_push_owns_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!mem_we || (mem_wdata == push_data_i && mem_waddr == sp_inc[IDX_W-1:0])));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_i == 3'd1 || cmd_i == 3'd3 || cmd_i == 3'd5) |=> $stable(rdata_o));

endmodule

// File: tb/test_regstk_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against
// a behavioural model built from the requirements.
module test_regstk_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = '0;
    logic [1:0] bank_sel_i = '0;
    logic [2:0] reg_num_i = '0;
    logic [7:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       pop_i = 1'b0;
    logic [7:0] rdata_o;
    logic [7:0] pop_data_o;
    logic [7:0] sp_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] m_mem [128];
    logic [7:0] m_sp, m_rd, m_pop;

    always #10 clk = ~clk;

    regstk_top i_regstk_top (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_sel_i(bank_sel_i),
        .reg_num_i(reg_num_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
        .rdata_o(rdata_o), .pop_data_o(pop_data_o), .sp_o(sp_o)
    );

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        m_sp = 8'h07; m_rd = 8'h00; m_pop = 8'h00;
    endtask

    // Advance the model by one clock using the currently driven inputs.
    task automatic model_step();
        logic [7:0] idx;
        logic [2:0] pos;
        logic inr, isbit, rd, wr;
        idx = 8'h00; pos = addr_i[2:0]; inr = 1'b0; isbit = 1'b0;
        case (cmd_i)
            3'd1, 3'd2: begin idx = {3'b000, bank_sel_i, reg_num_i}; inr = 1'b1; end
            3'd3, 3'd4: begin idx = addr_i; inr = (addr_i < 8'h80); end
            3'd5, 3'd6: begin idx = 8'h20 + (addr_i >> 3); inr = (addr_i < 8'h80); isbit = 1'b1; end
            default: ;
        endcase
        rd = (cmd_i == 3'd1) || (cmd_i == 3'd3) || (cmd_i == 3'd5);
        wr = (cmd_i == 3'd2) || (cmd_i == 3'd4) || (cmd_i == 3'd6);
        if (rd) begin
            if (!inr)       m_rd = 8'h00;
            else if (isbit) m_rd = {7'b0, m_mem[idx[6:0]][pos]};
            else            m_rd = m_mem[idx[6:0]];
        end
        if (pop_i && !push_i) begin
            m_pop = (m_sp < 8'h80) ? m_mem[m_sp[6:0]] : 8'h00;
            m_sp  = m_sp - 8'd1;
        end
        if (push_i) begin
            m_sp = m_sp + 8'd1;
            if (m_sp < 8'h80) m_mem[m_sp[6:0]] = push_data_i;
        end else if (wr && inr) begin
            if (isbit) m_mem[idx[6:0]][pos] = wdata_i[0];
            else       m_mem[idx[6:0]] = wdata_i;
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        check(tag, "rdata_o", rdata_o, m_rd);
        check(tag, "pop_data_o", pop_data_o, m_pop);
        check(tag, "sp_o", sp_o, m_sp);
    endtask

    // One clock: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input string tag, input logic [2:0] c, input logic [1:0] bk,
                        input logic [2:0] rn, input logic [7:0] ad, input logic [7:0] wd,
                        input logic ps, input logic [7:0] pd, input logic pp);
        cmd_i = c; bank_sel_i = bk; reg_num_i = rn; addr_i = ad; wdata_i = wd;
        push_i = ps; push_data_i = pd; pop_i = pp;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic acc(input string tag, input logic [2:0] c, input logic [1:0] bk,
                       input logic [2:0] rn, input logic [7:0] ad, input logic [7:0] wd);
        step(tag, c, bk, rn, ad, wd, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic stk(input string tag, input logic ps, input logic [7:0] pd, input logic pp);
        step(tag, 3'd0, 2'd0, 3'd0, 8'h00, 8'h00, ps, pd, pp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_i = '0; push_i = 1'b0; pop_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_outputs("R1");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] seed_init;
        seed_init = $urandom(32'd1905);
        model_reset();
        do_reset();
        // R1: memory cleared
        acc("R1", 3'd3, 2'd0, 3'd0, 8'h7F, 8'h00);
        acc("R1", 3'd3, 2'd0, 3'd0, 8'h00, 8'h00);
        // R2: bank 2 register 5 is byte 15h; bank 3 register 7 is 1Fh
        acc("R2", 3'd2, 2'd2, 3'd5, 8'h00, 8'hA5);
        acc("R2", 3'd3, 2'd0, 3'd0, 8'h15, 8'h00);
        acc("R2", 3'd2, 2'd3, 3'd7, 8'h00, 8'h6E);
        acc("R2", 3'd3, 2'd0, 3'd0, 8'h1F, 8'h00);
        acc("R2", 3'd1, 2'd0, 3'd5, 8'h00, 8'h00);
        // R3: byte write/read at top of range, read-during-write old value
        acc("R3", 3'd4, 2'd0, 3'd0, 8'h7F, 8'h3C);
        acc("R3", 3'd3, 2'd0, 3'd0, 8'h7F, 8'h00);
        acc("R3", 3'd4, 2'd0, 3'd0, 8'h40, 8'h99);
        acc("R3", 3'd1, 2'd0, 3'd0, 8'h00, 8'h00);
        // R4: out-of-range byte write ignored, read returns zero
        acc("R4", 3'd4, 2'd0, 3'd0, 8'h80, 8'hFF);
        acc("R4", 3'd3, 2'd0, 3'd0, 8'h80, 8'h00);
        acc("R4", 3'd3, 2'd0, 3'd0, 8'h00, 8'h00);
        // R5: bit write/read with neighbours preserved
        acc("R5", 3'd6, 2'd0, 3'd0, 8'h0B, 8'h01);
        acc("R5", 3'd3, 2'd0, 3'd0, 8'h21, 8'h00);
        acc("R5", 3'd5, 2'd0, 3'd0, 8'h0B, 8'h00);
        acc("R5", 3'd6, 2'd0, 3'd0, 8'h0C, 8'hFF);
        acc("R5", 3'd6, 2'd0, 3'd0, 8'h0B, 8'hFE);
        acc("R5", 3'd3, 2'd0, 3'd0, 8'h21, 8'h00);
        acc("R5", 3'd4, 2'd0, 3'd0, 8'h2F, 8'hF0);
        acc("R5", 3'd6, 2'd0, 3'd0, 8'h7F, 8'h00);
        acc("R5", 3'd3, 2'd0, 3'd0, 8'h2F, 8'h00);
        // R6: out-of-range bit access
        acc("R6", 3'd6, 2'd0, 3'd0, 8'h85, 8'h01);
        acc("R6", 3'd3, 2'd0, 3'd0, 8'h20, 8'h00);
        acc("R6", 3'd5, 2'd0, 3'd0, 8'h85, 8'h00);
        // R7, R8: push two, inspect, pop in reverse order
        stk("R7", 1'b1, 8'h11, 1'b0);
        stk("R7", 1'b1, 8'h22, 1'b0);
        acc("R7", 3'd3, 2'd0, 3'd0, 8'h08, 8'h00);
        stk("R8", 1'b0, 8'h00, 1'b1);
        stk("R8", 1'b0, 8'h00, 1'b1);
        // R9: push and pop together
        stk("R9", 1'b1, 8'h33, 1'b1);
        acc("R9", 3'd3, 2'd0, 3'd0, 8'h08, 8'h00);
        // R10: push collides with byte write and bit write
        step("R10", 3'd4, 2'd0, 3'd0, 8'h50, 8'h77, 1'b1, 8'h44, 1'b0);
        acc("R10", 3'd3, 2'd0, 3'd0, 8'h50, 8'h00);
        step("R10", 3'd6, 2'd0, 3'd0, 8'h00, 8'h01, 1'b1, 8'h55, 1'b0);
        acc("R10", 3'd3, 2'd0, 3'd0, 8'h20, 8'h00);
        acc("R10", 3'd3, 2'd0, 3'd0, 8'h0A, 8'h00);
        // R11: pop down through zero, then push wraps to byte 00h
        for (int k = 0; k < 11; k++) stk("R11", 1'b0, 8'h00, 1'b1);
        stk("R11", 1'b0, 8'h00, 1'b1);
        stk("R11", 1'b1, 8'h5A, 1'b0);
        stk("R11", 1'b1, 8'h5B, 1'b0);
        acc("R11", 3'd3, 2'd0, 3'd0, 8'h00, 8'h00);
        stk("R11", 1'b0, 8'h00, 1'b1);
        // R12: idle codes and writes leave rdata_o alone
        acc("R12", 3'd7, 2'd0, 3'd0, 8'h00, 8'hFF);
        acc("R12", 3'd0, 2'd1, 3'd1, 8'h01, 8'hFF);
        acc("R12", 3'd2, 2'd1, 3'd1, 8'h01, 8'hC3);
        // R1: mid-run reset clears everything again
        do_reset();
        acc("R1", 3'd3, 2'd0, 3'd0, 8'h15, 8'h00);
        // Random traffic: R2 R3 R5 R7 R8 R9 R10 R11 mixed
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] c;
            logic [7:0] ad;
            c  = 3'($urandom % 8);
            ad = ($urandom % 8 == 0) ? 8'(8'h80 + $urandom % 128)
               : ($urandom % 2 == 0) ? 8'($urandom % 64) : 8'($urandom % 128);
            step("RND R2 R3 R5 R7 R8 R9 R10", c, 2'($urandom % 4), 3'($urandom % 8),
                 ad, 8'($urandom), ($urandom % 4 == 0), 8'($urandom), ($urandom % 4 == 0));
        end
        summary();
        $finish;
    end

endmodule